// File: doc/BRIEF.md
# Clock-divide controller with switchback

This block sets the internal clock rate of a small microcontroller core. It divides the oscillator clock into machine cycles of four phases each. It emits a strobe at the start of every machine cycle and at the start of every phase, the current phase number, and one tick enable per timer. A two-bit divide field selects the rate. Value `01` is the fast rate. Values `10` and `11` are two slow power-saving rates. Value `00` is reserved and is never stored. Software writes the field through a write strobe and reads it back on `div_o`. A new rate only takes hold at the start of the next machine cycle, so no strobe period is ever cut short.

With `swb_en` high, the block watches for events that need full speed and forces the field back to `01` without help from software. Each kind of event has its own point of effect:
- An acknowledged, qualified interrupt takes effect at the next C1 phase. If the instruction in progress writes an interrupt enable or priority register, it waits one more instruction first.
- A serial start bit takes effect as soon as its falling edge is seen on a receive line.
- A transmit-buffer write takes effect at the next instruction boundary.

The power-on, external and watchdog resets all force the fast rate at once.

The switchback control is a four-state machine:
- States: `SW_IDLE`, `SW_HOLD_CUR` (waiting for the end of the instruction that wrote an interrupt register), `SW_HOLD_NEXT` (waiting for the end of the following instruction) and `SW_WAIT_C1` (waiting for the next machine-cycle start).
- Transitions: `SW_IDLE`→`SW_WAIT_C1` on an interrupt acknowledge; `SW_IDLE`→`SW_HOLD_CUR` on an acknowledge during an interrupt-register write; `SW_HOLD_CUR`→`SW_HOLD_NEXT` and `SW_HOLD_NEXT`→`SW_WAIT_C1` on an instruction boundary; any state→`SW_IDLE` when a switchback is applied or `swb_en` is low.
- A separate transmit-pending flag runs beside the state machine.

Top module: `clkrate_ctrl`

## Requirements
- R1: Driving any of `rst_por_n`, `rst_ext_n` or `rst_wdt_n` low sets `div_o` to `01` at once, without waiting for a clock edge. Just after reset, `mc_stb` is 1, `phase_o` is 0 and every `tmr_tick` bit is 1.
- R2: The machine-cycle length depends on `div_o`: 4 clocks for `01`, 64 clocks for `10`, 1024 clocks for `11`. `mc_stb` is high for one clock at the start of each machine cycle.
- R3: Every machine cycle has four equal phases, numbered 0 to 3 on `phase_o`. `phase_stb` is high on the first clock of each phase (every 1, 16 or 256 clocks). `mc_stb` falls on phase 0.
- R4: `tmr_tick[i]` fires on every `mc_stb` when `tmr_fast[i]` is 1. When `tmr_fast[i]` is 0 it fires on every third `mc_stb` (every 12, 192 or 3072 clocks). A tick only ever fires together with `mc_stb`.
- R5: A write of `00` through `div_wr` leaves `div_o` unchanged.
- R6: A rate change takes effect only at a machine-cycle boundary. The machine cycle in progress runs for its full old length.
- R7: While `swb_en` is 0, interrupt acknowledges, receive falling edges and transmit writes leave `div_o` unchanged.
- R8: Each receive line passes through two flip-flops before falling-edge detection. With `rx_en[i]` high, `div_o` becomes `01` on the third rising edge after `rxd[i]` falls. With `rx_en[i]` low, a falling edge has no effect.
- R9: A `tx_wr` pulse makes `div_o` become `01` on the first later clock edge where `instr_stb` is high.
- R10: An `int_ack` pulse makes `div_o` become `01` on the edge where the next machine cycle starts. That edge is the one after which `mc_stb` is 1, and the next machine cycle is already 4 clocks long.
- R11: If `ie_wr_instr` is high together with `int_ack`, the switchback waits for two `instr_stb` pulses and only then for the next machine-cycle start.
- R12: While a switchback is pending, `div_wr` is ignored. A write in the same cycle as a new trigger is also ignored. When a receive edge and a write land on the same edge, the result is `01`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| rst_wdt_n | input | 1 | Watchdog reset, active low, asynchronous |
| div_wr | input | 1 | Write strobe for the divide field |
| div_wdata | input | 2 | Divide value to write (01, 10, 11) |
| swb_en | input | 1 | Switchback enable |
| int_ack | input | 1 | Pulse: a qualified interrupt was acknowledged |
| ie_wr_instr | input | 1 | The current instruction writes an interrupt enable or priority register |
| instr_stb | input | 1 | Pulse at each instruction boundary |
| rxd | input | N_SER | Serial receive lines, idle high |
| rx_en | input | N_SER | Receiver enable per serial port |
| tx_wr | input | N_SER | Transmit-buffer write strobe per serial port |
| tmr_fast | input | N_TMR | Per-timer tick select (1 = every machine cycle) |
| div_o | output | 2 | Current divide field |
| mc_stb | output | 1 | Start-of-machine-cycle strobe |
| phase_stb | output | 1 | Start-of-phase strobe |
| phase_o | output | 2 | Current phase number (0 = C1) |
| tmr_tick | output | N_TMR | Timer tick enables |

## Verification
The collision that matters most is a software write to the divide field landing in the same cycle as a switchback. The bench provokes it three ways:
- a write issued after a transmit trigger, while the switchback is still pending;
- a write on the same edge as a transmit-buffer write;
- a write timed so that it reaches the edge where a delayed receive falling edge applies.

In each case the bench expects `div_o` to end at `01`, or to hold its slow value until the instruction boundary, and never to take the written `10`. A second overlap is a switchback that arrives in the middle of a slow machine cycle. The bench counts clocks between `mc_stb` pulses and expects the interrupted cycle to keep its full 1024-clock length and the one after it to last 4 clocks.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

    typedef enum logic [1:0] {
        DIV_RSVD = 2'b00,
        DIV_FAST = 2'b01,
        DIV_PM1  = 2'b10,
        DIV_PM2  = 2'b11
    } div_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_HOLD_CUR,
        SW_HOLD_NEXT,
        SW_WAIT_C1
    } swb_state_e;

endpackage

// File: rtl/clkrate_rx_edge.sv
module clkrate_rx_edge #(
    parameter int N_SER       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SER-1:0] rxd,
    output logic [N_SER-1:0] fall
);

    // One shift chain per port: SYNC_STAGES synchronizer flops plus one history flop.
    for (genvar g = 0; g < N_SER; g++) begin : g_port
        logic [SYNC_STAGES:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[SYNC_STAGES-1:0], rxd[g]};
            end
        end

        assign fall[g] = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
    end

endmodule

// File: rtl/clkrate_divider.sv
module clkrate_divider
    import clkrate_pkg::*;
#(
    parameter int MC_LOG2     = 2,
    parameter int STEP_LOG2   = 4,
    parameter int PH_LOG2     = 2,
    parameter int TMR_SLOW_MC = 3,
    parameter int N_TMR       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  div_e               div_next,
    input  logic [N_TMR-1:0]   tmr_fast,
    output logic               mc_stb,
    output logic               mc_last,
    output logic               phase_stb,
    output logic [PH_LOG2-1:0] phase_o,
    output logic [N_TMR-1:0]   tmr_tick
);

    localparam int CNT_W = MC_LOG2 + 2 * STEP_LOG2;
    localparam int LEN_W = $clog2(CNT_W + 1);
    localparam int MCC_W = $clog2(TMR_SLOW_MC);

    div_e               cur_div;
    logic [CNT_W-1:0]   cnt;
    logic [MCC_W-1:0]   mc_cnt;
    logic [LEN_W-1:0]   len_l2;
    logic [LEN_W-1:0]   ph_shift;
    logic [CNT_W-1:0]   last_val;
    logic [CNT_W-1:0]   ph_mask;

    function automatic logic [LEN_W-1:0] len_of(input div_e d);
        logic [LEN_W-1:0] r;
        unique case (d)
            DIV_PM1: r = LEN_W'(MC_LOG2 + STEP_LOG2);
            DIV_PM2: r = LEN_W'(CNT_W);
            default: r = LEN_W'(MC_LOG2);
        endcase
        return r;
    endfunction

    assign len_l2   = len_of(cur_div);
    assign ph_shift = len_l2 - LEN_W'(PH_LOG2);
    assign last_val = ~({CNT_W{1'b1}} << len_l2);
    assign ph_mask  = ~({CNT_W{1'b1}} << ph_shift);

    assign mc_last   = (cnt == last_val);
    assign mc_stb    = (cnt == '0);
    assign phase_stb = ((cnt & ph_mask) == '0);
    assign phase_o   = PH_LOG2'(cnt >> ph_shift);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_div <= DIV_FAST;
            mc_cnt  <= '0;
        end else if (mc_last) begin
            cnt     <= '0;
            cur_div <= (div_next == DIV_RSVD) ? DIV_FAST : div_next;
            mc_cnt  <= (mc_cnt == MCC_W'(TMR_SLOW_MC - 1)) ? '0 : mc_cnt + 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        assign tmr_tick[t] = mc_stb & (tmr_fast[t] | (mc_cnt == '0));
    end

    // R6: the active rate moves only on the last clock of a machine cycle
    assert_boundary_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_last |=> $stable(cur_div));

endmodule

// File: rtl/clkrate_swb_fsm.sv
module clkrate_swb_fsm
    import clkrate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swb_en,
    input  logic int_ack,
    input  logic ie_wr_instr,
    input  logic instr_stb,
    input  logic tx_wr_any,
    input  logic rx_hit,
    input  logic mc_last,
    output logic sw_apply,
    output logic int_apply,
    output logic pending
);

    swb_state_e state, state_nx;
    logic       tx_pend, tx_pend_nx;
    logic       tx_apply;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SW_IDLE;
            tx_pend <= 1'b0;
        end else begin
            state   <= state_nx;
            tx_pend <= tx_pend_nx;
        end
    end

    // outputs
    always_comb begin
        int_apply = swb_en & (state == SW_WAIT_C1) & mc_last;
        tx_apply  = swb_en & tx_pend & instr_stb;
        sw_apply  = int_apply | tx_apply | (swb_en & rx_hit);
        pending   = (state != SW_IDLE) | tx_pend;
    end

    // next state
    always_comb begin
        state_nx   = state;
        tx_pend_nx = tx_pend;
        if (!swb_en || sw_apply) begin
            state_nx   = SW_IDLE;
            tx_pend_nx = 1'b0;
        end else begin
            unique case (state)
                SW_IDLE:      if (int_ack)   state_nx = ie_wr_instr ? SW_HOLD_CUR : SW_WAIT_C1;
                SW_HOLD_CUR:  if (instr_stb) state_nx = SW_HOLD_NEXT;
                SW_HOLD_NEXT: if (instr_stb) state_nx = SW_WAIT_C1;
                SW_WAIT_C1:   state_nx = SW_WAIT_C1;
                default:      state_nx = SW_IDLE;
            endcase
            if (tx_wr_any) tx_pend_nx = 1'b1;
        end
    end

    // R11: a held interrupt cannot reach C1 wait without an instruction boundary
    assert_hold_needs_instr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_HOLD_NEXT && !instr_stb && swb_en) |=> (state == SW_HOLD_NEXT));

endmodule

// File: rtl/clkrate_ctrl.sv
module clkrate_ctrl
    import clkrate_pkg::*;
#(
    parameter int N_SER       = 2,
    parameter int N_TMR       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MC_LOG2     = 2,
    parameter int STEP_LOG2   = 4,
    parameter int TMR_SLOW_MC = 3
) (
    input  logic             clk,
    input  logic             rst_por_n,
    input  logic             rst_ext_n,
    input  logic             rst_wdt_n,
    input  logic             div_wr,
    input  logic [1:0]       div_wdata,
    input  logic             swb_en,
    input  logic             int_ack,
    input  logic             ie_wr_instr,
    input  logic             instr_stb,
    input  logic [N_SER-1:0] rxd,
    input  logic [N_SER-1:0] rx_en,
    input  logic [N_SER-1:0] tx_wr,
    input  logic [N_TMR-1:0] tmr_fast,
    output logic [1:0]       div_o,
    output logic             mc_stb,
    output logic             phase_stb,
    output logic [1:0]       phase_o,
    output logic [N_TMR-1:0] tmr_tick
);

    logic             rst_n;
    logic [N_SER-1:0] rx_fall;
    logic             rx_hit;
    logic             mc_last;
    logic             sw_apply;
    logic             int_apply;
    logic             pending;
    logic             new_evt;
    logic             wr_ok;
    div_e             div_q, div_nx;

    assign rst_n = rst_por_n & rst_ext_n & rst_wdt_n;

    clkrate_rx_edge #(
        .N_SER       (N_SER),
        .SYNC_STAGES (SYNC_STAGES)
    ) rx_edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .fall  (rx_fall)
    );

    assign rx_hit = |(rx_fall & rx_en);

    clkrate_swb_fsm swb_fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .swb_en      (swb_en),
        .int_ack     (int_ack),
        .ie_wr_instr (ie_wr_instr),
        .instr_stb   (instr_stb),
        .tx_wr_any   (|tx_wr),
        .rx_hit      (rx_hit),
        .mc_last     (mc_last),
        .sw_apply    (sw_apply),
        .int_apply   (int_apply),
        .pending     (pending)
    );

    assign new_evt = swb_en & (rx_hit | int_ack | (|tx_wr));
    assign wr_ok   = div_wr & ~pending & ~new_evt & (div_wdata != 2'b00);

    always_comb begin
        div_nx = div_q;
        if (sw_apply)   div_nx = DIV_FAST;
        else if (wr_ok) div_nx = div_e'(div_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= DIV_FAST;
        else        div_q <= div_nx;
    end

    assign div_o = div_q;

    clkrate_divider #(
        .MC_LOG2     (MC_LOG2),
        .STEP_LOG2   (STEP_LOG2),
        .PH_LOG2     (2),
        .TMR_SLOW_MC (TMR_SLOW_MC),
        .N_TMR       (N_TMR)
    ) divider_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_next  (div_nx),
        .tmr_fast  (tmr_fast),
        .mc_stb    (mc_stb),
        .mc_last   (mc_last),
        .phase_stb (phase_stb),
        .phase_o   (phase_o),
        .tmr_tick  (tmr_tick)
    );

    assert_reserved_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_q != DIV_RSVD);

    assert_disabled_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!swb_en && !div_wr) |=> $stable(div_q));

    assert_rx_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_en && rx_hit) |=> (div_q == DIV_FAST));

    assert_c1_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_apply |=> (div_q == DIV_FAST && mc_stb));

    assert_pending_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !sw_apply) |=> $stable(div_q));

    assert_tick_on_mc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_tick) |-> mc_stb);

endmodule

// File: tb/clkrate_ctrl_tb_top.sv
module clkrate_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0, rst_ext_n = 1'b1, rst_wdt_n = 1'b1;
    logic       div_wr = 1'b0;
    logic [1:0] div_wdata = 2'b00;
    logic       swb_en = 1'b0, int_ack = 1'b0, ie_wr_instr = 1'b0, instr_stb = 1'b0;
    logic [1:0] rxd = 2'b11, rx_en = 2'b00, tx_wr = 2'b00, tmr_fast = 2'b00;
    logic [1:0] div_o, phase_o, tmr_tick;
    logic       mc_stb, phase_stb;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clkrate_ctrl dut_i (
        .clk(clk), .rst_por_n(rst_por_n), .rst_ext_n(rst_ext_n), .rst_wdt_n(rst_wdt_n),
        .div_wr(div_wr), .div_wdata(div_wdata), .swb_en(swb_en), .int_ack(int_ack),
        .ie_wr_instr(ie_wr_instr), .instr_stb(instr_stb), .rxd(rxd), .rx_en(rx_en),
        .tx_wr(tx_wr), .tmr_fast(tmr_fast), .div_o(div_o), .mc_stb(mc_stb),
        .phase_stb(phase_stb), .phase_o(phase_o), .tmr_tick(tmr_tick)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mc();
        int lim = 0;
        do begin step(); lim++; end while (!mc_stb && lim < 5000);
    endtask

    task automatic mc_period(output int n);
        n = 0;
        do begin step(); n++; end while (!mc_stb && n < 5000);
    endtask

    task automatic tick_period(input int i, output int n);
        int lim = 0;
        do begin step(); lim++; end while (!tmr_tick[i] && lim < 5000);
        n = 0;
        do begin step(); n++; end while (!tmr_tick[i] && n < 5000);
    endtask

    task automatic set_div(input logic [1:0] d);
        div_wr = 1'b1; div_wdata = d;
        step();
        div_wr = 1'b0;
        wait_mc();
    endtask

    task automatic pulse_instr();
        instr_stb = 1'b1; step(); instr_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n, bad, len, ph, ex;
        step(3);
        rst_por_n = 1'b1;
        #1;
        // R1 reset state
        chk(div_o == 2'b01, "R1 reset div", div_o, 1);
        chk(mc_stb && phase_o == 0, "R1 reset mc_stb/phase", {mc_stb, phase_o}, 4);
        chk(tmr_tick == 2'b11, "R1 R4 reset ticks", tmr_tick, 3);
        step();

        // R2 R3 R4 sweep over rates
        for (int d = 1; d <= 3; d++) begin
            len = 4 << (4 * (d - 1));
            ph  = len / 4;
            tmr_fast = 2'b01;
            set_div(2'(d));
            chk(div_o == 2'(d), "R2 field readback", div_o, d);
            bad = 0;
            for (int k = 0; k < len; k++) begin
                if (phase_o != 2'(k / ph) || phase_stb != (k % ph == 0) || mc_stb != (k == 0))
                    bad++;
                step();
            end
            chk(bad == 0 && mc_stb, "R3 phase walk mismatches", bad, 0);
            wait_mc();
            mc_period(n);
            chk(n == len, "R2 machine-cycle length", n, len);
            tick_period(0, n);
            chk(n == len, "R4 fast tick period", n, len);
            tick_period(1, n);
            chk(n == 3 * len, "R4 slow tick period", n, 3 * len);
            tmr_fast = 2'b10;
            tick_period(0, n);
            chk(n == 3 * len, "R4 slow tick period swapped", n, 3 * len);
            tick_period(1, n);
            chk(n == len, "R4 fast tick period swapped", n, len);
        end

        // R5 reserved write ignored
        div_wr = 1'b1; div_wdata = 2'b00; step(); div_wr = 1'b0;
        wait_mc();
        chk(div_o == 2'b11, "R5 reserved write", div_o, 3);

        // R7 triggers ignored while disabled
        swb_en = 1'b0; rx_en = 2'b11;
        int_ack = 1'b1; tx_wr = 2'b11; step(); int_ack = 1'b0; tx_wr = 2'b00;
        rxd = 2'b00; step(3); pulse_instr();
        wait_mc(); step(2);
        chk(div_o == 2'b11, "R7 disabled triggers", div_o, 3);
        rxd = 2'b11; step(5);
        chk(div_o == 2'b11, "R7 after line release", div_o, 3);

        // R8 receive without enable
        swb_en = 1'b1; rx_en = 2'b00;
        rxd[1] = 1'b0; step(6);
        chk(div_o == 2'b11, "R8 rx edge without enable", div_o, 3);
        rxd[1] = 1'b1; step(4);

        // R8 R6 receive trigger mid-cycle; old cycle completes
        rx_en = 2'b10;
        wait_mc();
        step(100);
        rxd[1] = 1'b0;
        step(2);
        chk(div_o == 2'b11, "R8 before sync delay", div_o, 3);
        step();
        chk(div_o == 2'b01, "R8 after sync delay", div_o, 1);
        n = 103;
        do begin step(); n++; end while (!mc_stb && n < 5000);
        chk(n == 1024, "R6 interrupted cycle length", n, 1024);
        mc_period(n);
        chk(n == 4, "R6 following cycle length", n, 4);
        rxd[1] = 1'b1; step(4);

        // R9 transmit trigger
        set_div(2'b11);
        tx_wr = 2'b01; step(); tx_wr = 2'b00;
        step(5);
        chk(div_o == 2'b11, "R9 before boundary", div_o, 3);
        pulse_instr();
        chk(div_o == 2'b01, "R9 at boundary", div_o, 1);

        // R12 write while pending
        set_div(2'b11);
        tx_wr = 2'b10; step(); tx_wr = 2'b00;
        div_wr = 1'b1; div_wdata = 2'b10; step(); div_wr = 1'b0;
        chk(div_o == 2'b11, "R12 write while pending", div_o, 3);
        pulse_instr();
        chk(div_o == 2'b01, "R12 pending then boundary", div_o, 1);

        // R12 write in the same cycle as a transmit trigger
        set_div(2'b11);
        tx_wr = 2'b01; div_wr = 1'b1; div_wdata = 2'b10; step();
        tx_wr = 2'b00; div_wr = 1'b0;
        chk(div_o == 2'b11, "R12 simultaneous tx write", div_o, 3);
        pulse_instr();
        chk(div_o == 2'b01, "R12 simultaneous then boundary", div_o, 1);

        // R12 write on the edge a receive trigger applies
        set_div(2'b11);
        rx_en = 2'b01; rxd[0] = 1'b0; step(2);
        div_wr = 1'b1; div_wdata = 2'b10; step(); div_wr = 1'b0;
        chk(div_o == 2'b01, "R12 rx beats write", div_o, 1);
        rxd[0] = 1'b1; step(4);

        // R10 interrupt waits for next C1
        set_div(2'b11);
        step(50);
        int_ack = 1'b1; step(); int_ack = 1'b0;
        n = 51; bad = 0;
        while (!mc_stb && n < 5000) begin
            if (div_o != 2'b11) bad++;
            step(); n++;
        end
        chk(bad == 0, "R10 early switch samples", bad, 0);
        chk(n == 1024 && div_o == 2'b01, "R10 switch at C1", n, 1024);
        mc_period(n);
        chk(n == 4, "R10 fast cycle after switch", n, 4);

        // R11 deferral after interrupt register write
        set_div(2'b11);
        step(10);
        ie_wr_instr = 1'b1; int_ack = 1'b1; step(); int_ack = 1'b0; ie_wr_instr = 1'b0;
        wait_mc();
        chk(div_o == 2'b11, "R11 held over first boundary", div_o, 3);
        step(5); pulse_instr();
        wait_mc();
        chk(div_o == 2'b11, "R11 held after one instruction", div_o, 3);
        step(5); pulse_instr();
        chk(div_o == 2'b11, "R11 waits for C1", div_o, 3);
        wait_mc();
        chk(div_o == 2'b01, "R11 switch at C1", div_o, 1);

        // R1 each reset source, asynchronous
        for (int r = 0; r < 3; r++) begin
            set_div(2'b11);
            step(7);
            #1;
            if (r == 0) rst_por_n = 1'b0;
            else if (r == 1) rst_ext_n = 1'b0;
            else rst_wdt_n = 1'b0;
            #0.5;
            ex = 1;
            chk(div_o == 2'(ex), $sformatf("R1 async reset source %0d", r), div_o, ex);
            step();
            rst_por_n = 1'b1; rst_ext_n = 1'b1; rst_wdt_n = 1'b1;
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule